// File: doc/BRIEF.md
# Configurable Multi-Source Trigger Detector

This block turns four asynchronous trigger sources into a single one-cycle trigger pulse in the local clock domain. Two of the sources are external pins. Each pin can be watched for a low level, a high level, any edge, a rising edge or a falling edge, and any mix of these conditions can be selected at once. The other two sources are internal level requests, one from an ADC and one from a logic analyzer. Every source has its own enable bit.

All four inputs pass through a two-flop synchroniser. Each pin also keeps its previous synchronised sample, which the edge conditions compare against. For each pin, the selected conditions are ORed together. The enabled sources are then ORed into a combined condition, and a registered pulse is emitted when that condition becomes true. A level that stays true therefore fires only once and must drop before it can fire again.

Configuration is a 20-bit word. The block assumes the word is quasi-static, or at least synchronous to the local clock.

Top module: `trig_detect_top`

## Requirements
- R1: While reset is active, and on the first three clock edges after reset is released, trig_o is 0. During this time the synchroniser and the previous-sample register fill with real pin samples. A condition that is already true at that point gives a pulse after the fourth edge.
- R2: Config bit i (i = 0 or 1) selects a low-level condition on ext_pin_i[i]. It is true while the synchronised pin is 0.
- R3: Config bit 2+i selects a high-level condition on ext_pin_i[i]. It is true while the synchronised pin is 1.
- R4: Config bit 4+i selects an any-edge condition on ext_pin_i[i]. It is true for the one cycle in which the synchronised pin differs from its previous sample.
- R5: Config bit 6+i selects a rising-edge condition on ext_pin_i[i]. It is true when the synchronised pin is 1 and its previous sample was 0.
- R6: Config bit 8+i selects a falling-edge condition on ext_pin_i[i]. It is true when the synchronised pin is 0 and its previous sample was 1.
- R7: Enable bits: bit 16 enables pin 0, bit 17 enables pin 1, bit 18 enables the ADC trigger and bit 19 enables the logic-analyzer trigger. A disabled source has no effect on trig_o. When bits 19:16 are all clear, trig_o stays 0. Config bits 15:10 are ignored.
- R8: trig_o is high for exactly one cycle each time the combined condition goes from false to true. No further pulse comes while the condition stays true.
- R9: An input change that is presented before clock edge k appears on trig_o after edge k+2, that is, three edges later.
- R10: The ADC and logic-analyzer inputs are level conditions. An enabled one that is synchronised high makes the combined condition true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 20 | Condition selects (bits 9:0) and source enables (bits 19:16) |
| ext_pin_i | input | 2 | Asynchronous external trigger pins |
| adc_trig_i | input | 1 | Asynchronous ADC trigger level |
| la_trig_i | input | 1 | Asynchronous logic-analyzer trigger level |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The sweep covers all 32 combinations of condition selects on each pin in turn. Each combination is driven with the same 16-cycle pin waveform, which mixes single-cycle glitches, a long high, a long low and back-to-back toggles. This shows which condition was detected and shows that edges are absorbed while a level condition is already holding. During the sweep the other pin toggles against the driven pin with its selects clear, which shows the pins are independent. Further patterns pulse and hold the internal levels with various enable masks, toggle everything with all enables clear, and run directed cases. These cases measure the three-edge latency, the single pulse for a held level, and the quiet startup window.

// File: rtl/trig_pkg.sv
// Shared field positions and types for the trigger detector.
// Assumes exactly two external pins; the configuration layout depends on it.
package trig_pkg;
    localparam int CFG_W    = 20;
    localparam int N_EXT    = 2;
    localparam int N_SRC    = N_EXT + 2;
    localparam int SEL_LOW  = 0;
    localparam int SEL_HIGH = 2;
    localparam int SEL_ANY  = 4;
    localparam int SEL_RISE = 6;
    localparam int SEL_FALL = 8;
    localparam int EN_LSB   = 16;

    typedef struct packed {
        logic low;
        logic high;
        logic any;
        logic rise;
        logic fall;
    } pin_sel_t;

    // Extract the five condition selects belonging to one pin.
    function automatic pin_sel_t pick_sel(input logic [CFG_W-1:0] cfg, input int idx);
        pin_sel_t s;
        s.low  = cfg[SEL_LOW  + idx];
        s.high = cfg[SEL_HIGH + idx];
        s.any  = cfg[SEL_ANY  + idx];
        s.rise = cfg[SEL_RISE + idx];
        s.fall = cfg[SEL_FALL + idx];
        return s;
    endfunction
endpackage

// File: rtl/trig_sync.sv
// Multi-bit synchroniser: each bit passes independently through STAGES flops.
// Assumes the bits are unrelated, so no coherence across bits is needed.
module trig_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= async_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/trig_warmup.sv
// Counts edges after reset and reports when the sample pipeline holds real data.
// Assumes COUNT is small; the counter saturates.
module trig_warmup #(
    parameter int COUNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic primed_o
);
    localparam int CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(COUNT);

    logic [CW-1:0] cnt_q;

    // Saturating post-reset edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign primed_o = (cnt_q == LIMIT);
endmodule

// File: rtl/trig_pin_eval.sv
// Evaluates the selected conditions of one external pin and ORs them.
// Assumes cur_i and prev_i are consecutive synchronised samples.
module trig_pin_eval
    import trig_pkg::*;
(
    input  pin_sel_t sel_i,
    input  logic     cur_i,
    input  logic     prev_i,
    output logic     hit_o
);
    logic lvl_lo, lvl_hi, edg_any, edg_up, edg_dn;

    // Decode each condition from the current and previous samples.
    always_comb begin
        lvl_lo  = sel_i.low  & ~cur_i;
        lvl_hi  = sel_i.high &  cur_i;
        edg_any = sel_i.any  & (cur_i ^ prev_i);
        edg_up  = sel_i.rise &  cur_i & ~prev_i;
        edg_dn  = sel_i.fall & ~cur_i &  prev_i;
        hit_o   = lvl_lo | lvl_hi | edg_any | edg_up | edg_dn;
    end
endmodule

// File: rtl/trig_pulse.sv
// Converts the combined trigger condition into a one-cycle pulse on its rise.
// Assumes the condition is already synchronous to clk.
module trig_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic pulse_o,
    output logic held_o
);
    logic held_q, pulse_q;

    // Remember the condition and fire when it turns true.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            held_q  <= cond_i;
            pulse_q <= cond_i & ~held_q;
        end
    end

    assign pulse_o = pulse_q;
    assign held_o  = held_q;
endmodule

// File: rtl/trig_detect_top.sv
// Multi-source trigger detector: synchronises two pins and two internal levels,
// applies per-pin conditions and per-source enables, and emits a single pulse.
// Assumes cfg_i is quasi-static or synchronous to clk.
module trig_detect_top
    import trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [N_EXT-1:0] ext_pin_i,
    input  logic             adc_trig_i,
    input  logic             la_trig_i,
    output logic             trig_o
);
    localparam int WARM = SYNC_STAGES + 1;

    logic [N_SRC-1:0] sync_q;
    logic [N_EXT-1:0] prev_q;
    logic [N_SRC-1:0] src_hit;
    logic [N_SRC-1:0] src_en;
    logic             primed;
    logic             cond_raw;
    logic             cond_held;
    logic             unused_cfg;

    assign unused_cfg = ^cfg_i[EN_LSB-1:SEL_FALL+N_EXT];

    trig_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({la_trig_i, adc_trig_i, ext_pin_i}),
        .sync_o  (sync_q)
    );

    // Keep the previous synchronised pin samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sync_q[N_EXT-1:0];
        end
    end

    generate
        for (genvar p = 0; p < N_EXT; p++) begin : g_pin
            trig_pin_eval u_eval (
                .sel_i  (pick_sel(cfg_i, p)),
                .cur_i  (sync_q[p]),
                .prev_i (prev_q[p]),
                .hit_o  (src_hit[p])
            );
        end
    endgenerate

    assign src_hit[N_SRC-1:N_EXT] = sync_q[N_SRC-1:N_EXT];
    assign src_en                 = cfg_i[EN_LSB +: N_SRC];

    trig_warmup #(.COUNT(WARM)) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .primed_o (primed)
    );

    // Merge enabled sources once the sample pipeline is valid.
    always_comb begin
        cond_raw = primed & (|(src_hit & src_en));
    end

    trig_pulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_i  (cond_raw),
        .pulse_o (trig_o),
        .held_o  (cond_held)
    );
endmodule

// File: rtl/trig_detect_chk.sv
// Checker for trig_detect_top: port-level timing rules plus source-to-pulse rules.
// Assumes the default two-stage synchroniser (startup window of three edges).
module trig_detect_chk
    import trig_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_i,
    input logic             trig_o,
    input logic [N_SRC-1:0] sync_q,
    input logic             primed,
    input logic             cond_held
);
    logic [2:0] edges_q;

    // Count edges since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q <= '0;
        end else if (edges_q != 3'd7) begin
            edges_q <= edges_q + 3'd1;
        end
    end

    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q <= 3'd3) |-> !trig_o);

    a_r7_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[EN_LSB +: N_SRC] == '0) |=> !trig_o);

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    a_r10_adc_level: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[N_EXT] && cfg_i[EN_LSB + N_EXT] && primed) |=> (trig_o || $past(cond_held)));

    a_r2_low_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_q[0] && cfg_i[SEL_LOW] && cfg_i[EN_LSB] && primed) |=> (trig_o || $past(cond_held)));
endmodule

bind trig_detect_top trig_detect_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     (cfg_i),
    .trig_o    (trig_o),
    .sync_q    (sync_q),
    .primed    (primed),
    .cond_held (cond_held)
);

// File: tb/tb_trig_detect_top.sv
`timescale 1ns/1ps
// Bench for trig_detect_top: condition-select sweep plus directed cases,
// compared each cycle against a model built from the requirements.
module tb_trig_detect_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg = '0;
    logic [1:0]  pins = '0;
    logic        adc = 1'b0;
    logic        la = 1'b0;
    logic        trig;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trig_detect_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg),
        .ext_pin_i  (pins),
        .adc_trig_i (adc),
        .la_trig_i  (la),
        .trig_o     (trig)
    );

    // Requirement model: input seen by logic two edges late, previous sample one more.
    logic [3:0] m_s1, m_s2;
    logic [1:0] m_p;
    logic [2:0] m_cnt;
    logic       m_rawq, m_trig, m_raw;

    always_comb begin
        m_raw = 1'b0;
        for (int i = 0; i < 2; i++) begin
            logic cur, prv, h;
            cur = m_s2[i];
            prv = m_p[i];
            h = (cfg[i] & ~cur) | (cfg[2+i] & cur) | (cfg[4+i] & (cur ^ prv))
              | (cfg[6+i] & cur & ~prv) | (cfg[8+i] & ~cur & prv);
            m_raw = m_raw | (h & cfg[16+i]);
        end
        m_raw = m_raw | (cfg[18] & m_s2[2]) | (cfg[19] & m_s2[3]);
        m_raw = m_raw & (m_cnt >= 3'd3);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_cnt <= '0; m_rawq <= 1'b0; m_trig <= 1'b0;
        end else begin
            m_s1   <= {la, adc, pins};
            m_s2   <= m_s1;
            m_p    <= m_s2[1:0];
            m_cnt  <= (m_cnt == 3'd7) ? m_cnt : m_cnt + 3'd1;
            m_rawq <= m_raw;
            m_trig <= m_raw & ~m_rawq;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: trig_o actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive inputs at the falling edge, clock once, compare with the model.
    task automatic tick(input logic [1:0] p, input logic a, input logic l, input string tag);
        pins = p; adc = a; la = l;
        @(posedge clk);
        @(negedge clk);
        check(tag, trig, m_trig);
    endtask

    function automatic logic [19:0] mk_cfg(input int pin, input logic [4:0] c);
        logic [19:0] v = '0;
        for (int k = 0; k < 5; k++) v[2*k + pin] = c[k];
        v[16 + pin] = 1'b1;
        return v;
    endfunction

    function automatic string sel_tag(input logic [4:0] c);
        if (c == 5'd0) return "R7";
        if (c[0]) return "R2";
        if (c[1]) return "R3";
        if (c[2]) return "R4";
        if (c[3]) return "R5";
        return "R6";
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] wave;
        int n, pulses;
        wave = 16'b0011_0100_1110_0010;

        // R1: reset state and quiet startup with low-level already true.
        cfg = 20'h30003;
        repeat (3) @(negedge clk);
        check("R1", trig, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick(2'b00, 1'b0, 1'b0, "R1");
            check("R1", trig, 1'b0);
        end
        tick(2'b00, 1'b0, 1'b0, "R1");
        check("R1", trig, 1'b1);
        tick(2'b11, 1'b0, 1'b0, "R8");
        repeat (4) tick(2'b11, 1'b0, 1'b0, "R8");

        // R2..R6 sweep: every condition-select mix on each pin.
        for (int pin = 0; pin < 2; pin++) begin
            for (int c = 0; c < 32; c++) begin
                cfg = mk_cfg(pin, 5'(c));
                for (int t = 0; t < 16; t++) begin
                    logic b;
                    logic [1:0] pv;
                    b = wave[t];
                    pv = (pin == 0) ? {~b, b} : {b, ~b};
                    tick(pv, 1'b0, 1'b0, sel_tag(5'(c)));
                end
            end
        end

        // R10: internal level triggers under several enable masks.
        for (int m = 0; m < 4; m++) begin
            cfg = {m[1:0], 2'b00, 16'h0000};
            for (int t = 0; t < 16; t++)
                tick(2'b00, wave[t], wave[15-t], "R10");
        end

        // R7: pin conditions selected but pin enables clear, only ADC enabled.
        cfg = 20'h403FF;
        for (int t = 0; t < 16; t++)
            tick({wave[t], ~wave[t]}, 1'b0, 1'b0, "R7");

        // R7: all enables clear, every select set, everything toggling.
        cfg = 20'h0FFFF;
        for (int t = 0; t < 40; t++) begin
            tick({t[0], t[1]}, t[2], t[0], "R7");
            check("R7", trig, 1'b0);
        end

        // R9: rising edge on pin 1 reaches trig_o after three edges.
        cfg = mk_cfg(1, 5'b01000);
        repeat (6) tick(2'b00, 1'b0, 1'b0, "R9");
        n = 0;
        for (int k = 1; k <= 6; k++) begin
            tick(2'b10, 1'b0, 1'b0, "R9");
            if (trig && n == 0) n = k;
        end
        total++;
        if (n != 3) begin
            bad++;
            $display("FAIL R9: latency actual=%0d expected=3", n);
        end

        // R8: a held high level fires once only.
        cfg = mk_cfg(0, 5'b00010);
        repeat (6) tick(2'b00, 1'b0, 1'b0, "R8");
        pulses = 0;
        for (int k = 0; k < 12; k++) begin
            tick(2'b01, 1'b0, 1'b0, "R8");
            if (trig) pulses++;
        end
        total++;
        if (pulses != 1) begin
            bad++;
            $display("FAIL R8: pulses actual=%0d expected=1", pulses);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule